// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block sits between a chip's interrupt sources and the processor core. It receives one non-maskable request line and a parameterised set of maskable request lines. Each maskable line has its own 5-bit level register, loaded through a simple write port. On every clock the block chooses a single winning cause and presents that cause's level, interrupt number, vector table offset and default vector address to the core. The outputs are registered.

A smaller level value means a more urgent cause, and the value 31 switches a source off. The non-maskable request always wins and reports a fixed level. Ties between maskable sources go to the lowest source index. The block does not compare the winner against the core's current mask, does not clear requests, and does not fetch vectors.

Top module: `irq_prio_resolver`

## Requirements
- R1: One clock after `nmi_req` is sampled high, `sel_valid` is 1, `sel_num` is 15 (0x0F) and `sel_level` is 15, whatever the maskable requests and levels are.
- R2: A maskable source whose level register holds 31 is never selected, even while its request line is high.
- R3: Among the maskable sources that are requesting and enabled, the one with the numerically smallest level value is selected, and its level appears on `sel_level`.
- R4: When several enabled, requesting sources share the smallest level, the one with the lowest source index wins.
- R5: Maskable source n reports interrupt number 16+n on `sel_num` (source 0 gives 0x10, source 11 gives 0x1B).
- R6: When `sel_valid` is 1, `sel_offset` equals 0x3FC minus 4 times `sel_num`, and `sel_vaddr` equals 0x000FFC00 plus `sel_offset` (the non-maskable request gives 0x3C0 and 0x000FFFC0).
- R7: When neither the non-maskable request nor any enabled maskable request is pending, `sel_valid` is 0, `sel_level` is 31, and `sel_num`, `sel_offset` and `sel_vaddr` are 0. This is also the state of the outputs during reset.
- R8: After reset every level register holds 31, so no maskable request is selected until its level has been written.
- R9: A write with `cfg_we` high loads `cfg_lvl` into the level register of source `cfg_idx` at that clock edge. The new level takes part in the selection that appears on the outputs one clock later. Changes on the request lines likewise appear one clock after they are sampled.
- R10: A write to an index of `NUM_SRC` or above changes no level register. Nothing is written while `cfg_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request |
| irq_req | input | NUM_SRC | Maskable request lines, bit n is source n |
| cfg_we | input | 1 | Level register write strobe |
| cfg_idx | input | IDX_W | Source index to write |
| cfg_lvl | input | 5 | Level value to write |
| sel_valid | output | 1 | A cause is being presented |
| sel_level | output | 5 | Level of the winning cause |
| sel_num | output | 8 | Interrupt number of the winning cause |
| sel_offset | output | 10 | Vector table offset of the winner |
| sel_vaddr | output | 32 | Default vector address of the winner |

## Verification
A level write and a change on the request lines can land on the same clock edge. In that case the next registered outputs must reflect both, including a write that disables the current winner or moves a source into a tie. The bench provokes this by driving a pseudo-random write (often to an out-of-range index) and a fresh request pattern, sometimes with the non-maskable line, together in each iteration. It judges the outputs two edges later against a reference model of the level registers kept in the bench. Single-source sweeps and forced ties make up the rest.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int LVL_W = 5;
   localparam int NUM_W = 8;
   localparam int OFS_W = 10;
   localparam int ADR_W = 32;

   typedef logic [LVL_W-1:0] lvl_t;
   typedef logic [NUM_W-1:0] num_t;
   typedef logic [OFS_W-1:0] ofs_t;
   typedef logic [ADR_W-1:0] adr_t;

   localparam lvl_t LVL_OFF    = 5'd31;
   localparam lvl_t NMI_LVL    = 5'd15;
   localparam num_t NMI_NUM    = 8'h0F;
   localparam int   FIRST_NUM  = 16;
   localparam ofs_t OFS_TOP    = 10'h3FC;
   localparam adr_t VEC_BASE   = 32'h000F_FC00;
   localparam int   MAX_SRC    = 256 - FIRST_NUM;
endpackage

// File: rtl/irq_level_bank.sv
module irq_level_bank
   import irq_prio_pkg::*;
#(
   parameter int NUM_SRC = 12,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  lvl_t             wr_lvl,
   output lvl_t             lvl_o [NUM_SRC]
);
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lvl_o[s] <= LVL_OFF;
         else if (wr_en && (wr_idx == IDX_W'(s)))
            lvl_o[s] <= wr_lvl;
      end
   end

   // R10: an out-of-range or disabled write leaves every register unchanged
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
      a_r10_ignored_write : assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_en || (int'(wr_idx) != s)) |=> $stable(lvl_o[s]));
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_prio_pkg::*;
#(
   parameter int NUM_SRC = 12,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
)(
   input  logic [NUM_SRC-1:0] req_i,
   input  lvl_t               lvl_i [NUM_SRC],
   output logic               found_o,
   output logic [IDX_W-1:0]   idx_o,
   output lvl_t               lvl_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      lvl_o   = LVL_OFF;
      // ascending scan with strict compare keeps the lowest index on ties
      for (int s = 0; s < NUM_SRC; s++) begin
         if (req_i[s] && (lvl_i[s] < lvl_o)) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(s);
            lvl_o   = lvl_i[s];
         end
      end
   end
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map
   import irq_prio_pkg::*;
(
   input  logic valid_i,
   input  num_t num_i,
   output ofs_t ofs_o,
   output adr_t adr_o
);
   ofs_t raw_ofs;
   assign raw_ofs = OFS_TOP - {num_i, 2'b00};
   assign ofs_o   = valid_i ? raw_ofs : '0;
   assign adr_o   = valid_i ? (VEC_BASE + adr_t'(raw_ofs)) : '0;
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
   import irq_prio_pkg::*;
#(
   parameter int NUM_SRC = 12,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               nmi_req,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [4:0]         cfg_lvl,
   output logic               sel_valid,
   output logic [4:0]         sel_level,
   output logic [7:0]         sel_num,
   output logic [9:0]         sel_offset,
   output logic [31:0]        sel_vaddr
);
   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_cfg
      $error("irq_prio_resolver: NUM_SRC out of range");
   end

   lvl_t             lvl_q [NUM_SRC];
   logic             win_found;
   logic [IDX_W-1:0] win_idx;
   lvl_t             win_lvl;

   irq_level_bank #(.NUM_SRC(NUM_SRC)) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_idx (cfg_idx),
      .wr_lvl (cfg_lvl),
      .lvl_o  (lvl_q)
   );

   irq_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
      .req_i   (irq_req),
      .lvl_i   (lvl_q),
      .found_o (win_found),
      .idx_o   (win_idx),
      .lvl_o   (win_lvl)
   );

   logic nxt_valid;
   lvl_t nxt_lvl;
   num_t nxt_num;
   ofs_t nxt_ofs;
   adr_t nxt_adr;

   always_comb begin
      if (nmi_req) begin
         nxt_valid = 1'b1;
         nxt_lvl   = NMI_LVL;
         nxt_num   = NMI_NUM;
      end else if (win_found) begin
         nxt_valid = 1'b1;
         nxt_lvl   = win_lvl;
         nxt_num   = num_t'(FIRST_NUM) + num_t'(win_idx);
      end else begin
         nxt_valid = 1'b0;
         nxt_lvl   = LVL_OFF;
         nxt_num   = '0;
      end
   end

   irq_vec_map map_i (
      .valid_i (nxt_valid),
      .num_i   (nxt_num),
      .ofs_o   (nxt_ofs),
      .adr_o   (nxt_adr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_valid  <= 1'b0;
         sel_level  <= LVL_OFF;
         sel_num    <= '0;
         sel_offset <= '0;
         sel_vaddr  <= '0;
      end else begin
         sel_valid  <= nxt_valid;
         sel_level  <= nxt_lvl;
         sel_num    <= nxt_num;
         sel_offset <= nxt_ofs;
         sel_vaddr  <= nxt_adr;
      end
   end

   // R1: non-maskable request wins one clock later
   a_r1_nmi_wins : assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |=> (sel_valid && sel_num == NMI_NUM && sel_level == NMI_LVL));

   // R2: the arbiter never picks a disabled source
   a_r2_disabled_skipped : assert property (@(posedge clk) disable iff (!rst_n)
      win_found |-> (lvl_q[win_idx] != LVL_OFF && irq_req[win_idx]));

   // R3 and R4: no enabled requester beats the winner
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio_chk
      a_r3_lowest_level : assert property (@(posedge clk) disable iff (!rst_n)
         (irq_req[s] && lvl_q[s] != LVL_OFF) |-> (win_found && win_lvl <= lvl_q[s]));
      a_r4_tie_low_index : assert property (@(posedge clk) disable iff (!rst_n)
         (irq_req[s] && lvl_q[s] != LVL_OFF && lvl_q[s] == win_lvl) |-> (int'(win_idx) <= s));
   end

   // R6: offset and address agree with the presented number
   a_r6_vector_math : assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> ((sel_offset + {sel_num, 2'b00}) == OFS_TOP &&
                     sel_vaddr[31:10] == VEC_BASE[31:10] &&
                     sel_vaddr[9:0] == sel_offset));

   // R7: idle outputs
   a_r7_idle_outputs : assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |-> (sel_level == LVL_OFF && sel_num == '0 &&
                      sel_offset == '0 && sel_vaddr == '0));
endmodule

// File: tb/irq_prio_resolver_tb_top.sv
module irq_prio_resolver_tb_top;
   localparam int N  = 12;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          nmi_req = 1'b0;
   logic [N-1:0]  irq_req = '0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [4:0]    cfg_lvl = '0;
   logic          sel_valid;
   logic [4:0]    sel_level;
   logic [7:0]    sel_num;
   logic [9:0]    sel_offset;
   logic [31:0]   sel_vaddr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [4:0] mdl [N];
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   irq_prio_resolver #(.NUM_SRC(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl),
      .sel_valid(sel_valid), .sel_level(sel_level), .sel_num(sel_num),
      .sel_offset(sel_offset), .sel_vaddr(sel_vaddr));

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic chk(input string tag);
      logic       ev;
      logic [4:0] el;
      logic [7:0] en;
      logic [9:0] eo;
      logic [31:0] ea;
      ev = 1'b0; el = 5'd31; en = 8'd0;
      if (nmi_req) begin
         ev = 1'b1; el = 5'd15; en = 8'd15;
      end else begin
         for (int s = 0; s < N; s++)
            if (irq_req[s] && mdl[s] != 5'd31 && mdl[s] < el) begin
               ev = 1'b1; el = mdl[s]; en = 8'(16 + s);
            end
      end
      eo = ev ? 10'(1020 - 4 * int'(en)) : 10'd0;
      ea = ev ? (32'h000FFC00 + 32'(eo)) : 32'd0;
      checks++;
      if (sel_valid !== ev || sel_level !== el || sel_num !== en ||
          sel_offset !== eo || sel_vaddr !== ea) begin
         fails++;
         $display("FAIL %s: got v=%0d l=%0d n=%0h o=%0h a=%0h exp v=%0d l=%0d n=%0h o=%0h a=%0h",
                  tag, sel_valid, sel_level, sel_num, sel_offset, sel_vaddr,
                  ev, el, en, eo, ea);
      end
   endtask

   // drive inputs for one edge, optional write, then check after the register stage
   task automatic apply(input logic nmi, input logic [N-1:0] req,
                        input logic we, input int idx, input logic [4:0] lv,
                        input string tag);
      @(negedge clk);
      nmi_req = nmi; irq_req = req;
      cfg_we = we; cfg_idx = IW'(idx); cfg_lvl = lv;
      if (we && idx < N) mdl[idx] = lv;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(tag);
   endtask

   task automatic wr(input int idx, input logic [4:0] lv);
      apply(nmi_req, irq_req, 1'b1, idx, lv, "R9 write");
   endtask

   initial begin
      for (int s = 0; s < N; s++) mdl[s] = 5'd31;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R7 reset state");
      rst_n = 1'b1;

      // R8: all sources requesting but nothing enabled after reset
      apply(1'b0, '1, 1'b0, 0, 5'd0, "R8 reset levels 31");

      // R5 / R6: single source sweep, R2 when disabled again
      for (int s = 0; s < N; s++) begin
         apply(1'b0, N'(1) << s, 1'b1, s, 5'(s + 1), "R5 single source");
         apply(1'b0, N'(1) << s, 1'b1, s, 5'd31, "R2 disabled source");
      end

      // R3: descending levels, lowest value at the highest index
      for (int s = 0; s < N; s++) wr(s, 5'(30 - s));
      apply(1'b0, '1, 1'b0, 0, 5'd0, "R3 lowest level");
      // R4: ties
      for (int s = 0; s < N; s++) wr(s, 5'd7);
      apply(1'b0, '1, 1'b0, 0, 5'd0, "R4 tie all");
      apply(1'b0, N'(12'hA50), 1'b0, 0, 5'd0, "R4 tie subset");

      // R10: out-of-range writes must not alias onto real sources
      for (int s = 0; s < N; s++) wr(s, 5'd20);
      for (int k = N; k < 16; k++)
         apply(1'b0, '1, 1'b1, k, 5'd1, "R10 out of range write");
      apply(1'b0, '1, 1'b0, 3, 5'd1, "R10 strobe low");

      // R1: NMI over an urgent maskable source
      wr(5, 5'd0);
      apply(1'b1, '1, 1'b0, 0, 5'd0, "R1 nmi wins");
      apply(1'b1, '0, 1'b0, 0, 5'd0, "R1 nmi alone");
      // R9: write disabling the winner together with a new request
      apply(1'b0, N'(12'h021), 1'b1, 5, 5'd31, "R9 same-cycle write and request");
      apply(1'b0, '0, 1'b0, 0, 5'd0, "R7 idle");

      // mixed pseudo-random traffic
      for (int it = 0; it < 400; it++) begin
         logic [4:0] lv;
         logic       nmi;
         logic [N-1:0] rq;
         step_lfsr();
         lv  = lfsr[3] ? 5'd31 : {2'b00, lfsr[2:0]};
         nmi = (lfsr[15:12] == 4'hF);
         rq  = N'(lfsr ^ {lfsr[7:0], lfsr[15:8]});
         apply(nmi, rq, lfsr[4], int'(lfsr[11:8]), lv, "R3 R4 R9 mixed");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule